// File: doc/BRIEF.md
# Received Packet Payload Length Checker

This block sits on the receive side of a transaction layer. For every packet it compares the declared payload length with the configured maximum payload size, and with the number of payload DWs that actually arrive. A packet that fails either test is flagged as malformed. The header decoder supplies the relevant fields on the first beat of the packet: whether it carries data, whether it is a message, whether that message defines a data length, the 10-bit Length field, a digest flag and the target function number. The payload then arrives one DW per beat on a valid/start/end stream. When a digest is present, it is the last beat.

Each function has a 3-bit maximum payload size code. A mode input selects function-number-independent operation, in which only function 0's code counts. Otherwise the parameter `POLICY` chooses the limit. With `POLICY` 0 the limit is the targeted function's code. With `POLICY` 1 it is the largest code across all functions. The verdict is a single-cycle pulse with a reason code, and it appears one clock after the last beat of the packet.

Top module: `tlpchk_len_check`

## Requirements
- R1: The Length field counts 32-bit DWs, and a Length of 0 stands for 1024 DWs, both for the size limit and for the count comparison.
- R2: A packet whose has-data flag is low is never flagged, whatever its Length and beat count.
- R3: A message whose length-defined flag is low is not checked. A message with that flag high is checked like any data packet.
- R4: Size codes 0 to 5 give limits of 32, 64, 128, 256, 512 and 1024 DWs. Codes 6 and 7 give 32 DWs.
- R5: A checked packet whose Length exceeds the selected limit is flagged with reason 1 (oversize). A Length equal to the limit is accepted.
- R6: A checked packet whose received payload DW count differs from Length is flagged with reason 2 (mismatch).
- R7: When the digest flag is high, the final beat is a digest DW and is not counted as payload.
- R8: When a packet is both oversize and mismatched, the reason is 1.
- R9: With `ari_mode` high, function 0's size code sets the limit for every target function.
- R10: With `ari_mode` low, `POLICY`=0 uses the targeted function's code and `POLICY`=1 uses the largest code of all functions.
- R11: `bad_pulse` rises only in the cycle after a beat with `dw_eop`, lasts one cycle for an isolated packet, and `bad_reason` is 0 whenever `bad_pulse` is low, including after reset.
- R12: A checked packet within the limit and with a matching count produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dw_vld | input | 1 | Beat valid |
| dw_sop | input | 1 | First beat of a packet; header fields are sampled here |
| dw_eop | input | 1 | Last beat of a packet (the digest when present) |
| hdr_has_data | input | 1 | Packet carries a data payload |
| hdr_is_msg | input | 1 | Packet is a message |
| hdr_msg_len_ok | input | 1 | Message defines a data length |
| hdr_len | input | 10 | Length field in DWs, 0 means 1024 |
| hdr_digest | input | 1 | Trailing digest DW present |
| hdr_func | input | FUNC_W | Target function number |
| mps_cfg | input | 3*NUM_FUNC | Size code per function, function i at bits [3i+2:3i] |
| ari_mode | input | 1 | Use function 0's code for all functions |
| bad_pulse | output | 1 | Malformed-packet pulse |
| bad_reason | output | 2 | 0 none, 1 oversize, 2 length mismatch |

## Verification
The payload checks are exercised with Lengths just below, at and just above each limit, with counts that are one short, one long and exact, and with the digest present and absent. Oversize and mismatch are therefore each seen alone and together, which shows the priority. The same Length is sent to different functions in both selection modes, and to a second instance built with the largest-code policy, so that the targeted, function-0 and maximum policies give different verdicts. Unchecked classes (no data, length-less messages) carry Lengths that would otherwise fail, so that any leak appears as a pulse.

// File: rtl/tlpchk_pkg.sv
package tlpchk_pkg;
  localparam int LEN_W    = 10;
  localparam int LEN_DW_W = 11;

  typedef enum logic [1:0] {
    RSN_NONE     = 2'd0,
    RSN_OVERSIZE = 2'd1,
    RSN_MISMATCH = 2'd2
  } rsn_e;

  // Size code to DW limit; out-of-range codes fall back to the smallest size.
  function automatic logic [LEN_DW_W-1:0] mps_code_to_dw(input logic [2:0] code);
    if (code <= 3'd5) return LEN_DW_W'(32) << code;
    return LEN_DW_W'(32);
  endfunction

  // Length field to DW count; zero encodes the maximum.
  function automatic logic [LEN_DW_W-1:0] len_field_to_dw(input logic [LEN_W-1:0] len);
    if (len == '0) return LEN_DW_W'(1024);
    return {1'b0, len};
  endfunction
endpackage

// File: rtl/tlpchk_limit_sel.sv
module tlpchk_limit_sel
  import tlpchk_pkg::*;
#(
  parameter int NUM_FUNC = 4,
  parameter int POLICY   = 0,
  parameter int FUNC_W   = 2
) (
  input  logic [3*NUM_FUNC-1:0] mps_cfg,
  input  logic                  ari_mode,
  input  logic [FUNC_W-1:0]     func,
  output logic [LEN_DW_W-1:0]   limit_dw
);
  logic [LEN_DW_W-1:0] fn_dw [NUM_FUNC];
  logic [LEN_DW_W-1:0] pol_dw;

  for (genvar i = 0; i < NUM_FUNC; i++) begin : g_fn
    assign fn_dw[i] = mps_code_to_dw(mps_cfg[3*i +: 3]);
  end

  if (POLICY == 1) begin : g_max
    always_comb begin
      pol_dw = fn_dw[0];
      for (int i = 1; i < NUM_FUNC; i++)
        if (fn_dw[i] > pol_dw) pol_dw = fn_dw[i];
    end
  end else begin : g_tgt
    always_comb begin
      pol_dw = fn_dw[0];
      for (int i = 0; i < NUM_FUNC; i++)
        if (int'(func) == i) pol_dw = fn_dw[i];
    end
  end

  assign limit_dw = ari_mode ? fn_dw[0] : pol_dw;
endmodule

// File: rtl/tlpchk_beat_count.sv
module tlpchk_beat_count #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sop,
  input  logic             eop,
  output logic [CNT_W-1:0] cnt_now
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] base;

  assign base    = sop ? '0 : count_q;
  assign cnt_now = (base == CNT_MAX) ? CNT_MAX : base + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count_q <= '0;
    else if (beat) count_q <= eop ? '0 : cnt_now;
  end
endmodule

// File: rtl/tlpchk_len_check.sv
module tlpchk_len_check
  import tlpchk_pkg::*;
#(
  parameter int NUM_FUNC = 4,
  parameter int POLICY   = 0,
  parameter int CNT_W    = 12,
  localparam int FUNC_W  = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dw_vld,
  input  logic                  dw_sop,
  input  logic                  dw_eop,
  input  logic                  hdr_has_data,
  input  logic                  hdr_is_msg,
  input  logic                  hdr_msg_len_ok,
  input  logic [LEN_W-1:0]      hdr_len,
  input  logic                  hdr_digest,
  input  logic [FUNC_W-1:0]     hdr_func,
  input  logic [3*NUM_FUNC-1:0] mps_cfg,
  input  logic                  ari_mode,
  output logic                  bad_pulse,
  output logic [1:0]            bad_reason
);
  // Named internal events, used by the bound checker.
  logic [LEN_DW_W-1:0] limit_dw;
  logic                eop_fire;
  logic                chk_fire;
  logic                over_w;
  logic                mism_w;

  logic [CNT_W-1:0]    cnt_now;
  logic [CNT_W-1:0]    pay_dw;
  logic                sop_fire;

  logic                live_chk, live_over;
  logic [LEN_DW_W-1:0] live_len;
  logic                held_chk, held_over, held_dig;
  logic [LEN_DW_W-1:0] held_len;
  logic                eff_chk, eff_dig;
  logic [LEN_DW_W-1:0] eff_len;

  tlpchk_limit_sel #(
    .NUM_FUNC (NUM_FUNC),
    .POLICY   (POLICY),
    .FUNC_W   (FUNC_W)
  ) u_limit (
    .mps_cfg  (mps_cfg),
    .ari_mode (ari_mode),
    .func     (hdr_func),
    .limit_dw (limit_dw)
  );

  tlpchk_beat_count #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .beat    (dw_vld),
    .sop     (dw_sop),
    .eop     (dw_eop),
    .cnt_now (cnt_now)
  );

  assign sop_fire  = dw_vld && dw_sop;
  assign eop_fire  = dw_vld && dw_eop;
  assign live_chk  = hdr_has_data && (!hdr_is_msg || hdr_msg_len_ok);
  assign live_len  = len_field_to_dw(hdr_len);
  assign live_over = live_len > limit_dw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_chk  <= 1'b0;
      held_over <= 1'b0;
      held_dig  <= 1'b0;
      held_len  <= '0;
    end else if (sop_fire) begin
      held_chk  <= live_chk;
      held_over <= live_over;
      held_dig  <= hdr_digest;
      held_len  <= live_len;
    end
  end

  // A single-beat packet uses the header fields of its own beat.
  assign eff_chk = dw_sop ? live_chk   : held_chk;
  assign over_w  = dw_sop ? live_over  : held_over;
  assign eff_dig = dw_sop ? hdr_digest : held_dig;
  assign eff_len = dw_sop ? live_len   : held_len;

  assign pay_dw   = cnt_now - CNT_W'(eff_dig);
  assign mism_w   = pay_dw != CNT_W'(eff_len);
  assign chk_fire = eop_fire && eff_chk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_pulse  <= 1'b0;
      bad_reason <= RSN_NONE;
    end else begin
      bad_pulse  <= chk_fire && (over_w || mism_w);
      if (!chk_fire)   bad_reason <= RSN_NONE;
      else if (over_w) bad_reason <= RSN_OVERSIZE;
      else if (mism_w) bad_reason <= RSN_MISMATCH;
      else             bad_reason <= RSN_NONE;
    end
  end
endmodule

// File: rtl/tlpchk_sva.sv
module tlpchk_sva
  import tlpchk_pkg::*;
#(
  parameter int NUM_FUNC = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ari_mode,
  input logic [3*NUM_FUNC-1:0] mps_cfg,
  input logic [LEN_DW_W-1:0]   limit_dw,
  input logic                  eop_fire,
  input logic                  chk_fire,
  input logic                  over_w,
  input logic                  mism_w,
  input logic                  bad_pulse,
  input logic [1:0]            bad_reason
);
  // R11: a verdict follows only an end beat
  p_pulse_after_eop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bad_pulse |-> $past(eop_fire));

  // R11: reason stays zero outside a pulse
  p_reason_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_pulse |-> bad_reason == 2'd0);

  // R5: a pulse always carries a nonzero reason
  p_reason_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bad_pulse |-> bad_reason != 2'd0);

  // R8: oversize wins over mismatch
  p_oversize_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_fire && over_w) |=> (bad_pulse && bad_reason == 2'd1));

  // R6: mismatch alone gives reason 2
  p_mismatch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_fire && !over_w && mism_w) |=> (bad_pulse && bad_reason == 2'd2));

  // R2: unchecked packets stay quiet
  p_unchecked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_fire && !chk_fire) |=> !bad_pulse);

  // R4: the limit is a power of two between 32 and 1024 DWs
  p_limit_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_dw >= 11'd32) && (limit_dw <= 11'd1024) && ($countones(limit_dw) == 1));

  // R9: in function-0 mode the target function cannot move the limit
  p_ari_func0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ari_mode && $stable(ari_mode) && $stable(mps_cfg)) |-> $stable(limit_dw));
endmodule

bind tlpchk_len_check tlpchk_sva #(.NUM_FUNC(NUM_FUNC)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .ari_mode   (ari_mode),
  .mps_cfg    (mps_cfg),
  .limit_dw   (limit_dw),
  .eop_fire   (eop_fire),
  .chk_fire   (chk_fire),
  .over_w     (over_w),
  .mism_w     (mism_w),
  .bad_pulse  (bad_pulse),
  .bad_reason (bad_reason)
);

// File: tb/tlpchk_len_check_tb.sv
module tlpchk_len_check_tb;
  localparam int NF = 4;

  typedef struct packed {
    logic        has;
    logic        msg;
    logic        mlen;
    logic [9:0]  len;
    logic        dig;
    logic [1:0]  func;
    logic        ari;
    logic [11:0] beats;
    logic [1:0]  exp;
    logic [3:0]  req;
  } vec_t;

  // Size codes: f0=1 (64 DW), f1=0 (32 DW), f2=5 (1024 DW), f3=7 (32 DW)
  localparam logic [3*NF-1:0] CFG = {3'd7, 3'd5, 3'd0, 3'd1};

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,10'd16, 1'b0,2'd0,1'b0,12'd16,  2'd0,4'd12}, // R12 clean
    '{1'b1,1'b0,1'b0,10'd64, 1'b0,2'd0,1'b0,12'd64,  2'd0,4'd5},  // R5 at limit
    '{1'b1,1'b0,1'b0,10'd65, 1'b0,2'd0,1'b0,12'd65,  2'd1,4'd5},  // R5 over
    '{1'b1,1'b0,1'b0,10'd33, 1'b0,2'd1,1'b0,12'd33,  2'd1,4'd10}, // R10 targeted f1
    '{1'b1,1'b0,1'b0,10'd33, 1'b0,2'd1,1'b1,12'd33,  2'd0,4'd9},  // R9 f0 limit
    '{1'b1,1'b0,1'b0,10'd100,1'b0,2'd2,1'b1,12'd100, 2'd1,4'd9},  // R9 f2 ignored
    '{1'b1,1'b0,1'b0,10'd100,1'b0,2'd2,1'b0,12'd100, 2'd0,4'd10}, // R10 f2
    '{1'b1,1'b0,1'b0,10'd33, 1'b0,2'd3,1'b0,12'd33,  2'd1,4'd4},  // R4 code 7
    '{1'b1,1'b0,1'b0,10'd32, 1'b0,2'd3,1'b0,12'd32,  2'd0,4'd4},  // R4 code 7 edge
    '{1'b1,1'b0,1'b0,10'd10, 1'b0,2'd0,1'b0,12'd9,   2'd2,4'd6},  // R6 short
    '{1'b1,1'b0,1'b0,10'd10, 1'b0,2'd0,1'b0,12'd11,  2'd2,4'd6},  // R6 long
    '{1'b1,1'b0,1'b0,10'd10, 1'b1,2'd0,1'b0,12'd11,  2'd0,4'd7},  // R7 digest
    '{1'b1,1'b0,1'b0,10'd10, 1'b1,2'd0,1'b0,12'd10,  2'd2,4'd7},  // R7 digest eats one
    '{1'b1,1'b0,1'b0,10'd70, 1'b0,2'd0,1'b0,12'd5,   2'd1,4'd8},  // R8 both
    '{1'b0,1'b0,1'b0,10'd500,1'b0,2'd0,1'b0,12'd1,   2'd0,4'd2},  // R2 no data
    '{1'b1,1'b1,1'b0,10'd900,1'b0,2'd0,1'b0,12'd3,   2'd0,4'd3},  // R3 lengthless msg
    '{1'b1,1'b1,1'b1,10'd900,1'b0,2'd0,1'b0,12'd900, 2'd1,4'd3},  // R3 msg with length
    '{1'b1,1'b0,1'b0,10'd0,  1'b0,2'd2,1'b0,12'd1024,2'd0,4'd1},  // R1 zero = 1024
    '{1'b1,1'b0,1'b0,10'd0,  1'b0,2'd0,1'b0,12'd1024,2'd1,4'd1},  // R1 zero oversize
    '{1'b1,1'b0,1'b0,10'd1,  1'b0,2'd0,1'b0,12'd1,   2'd0,4'd11}  // R11 single beat
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dw_vld = 1'b0, dw_sop = 1'b0, dw_eop = 1'b0;
  logic hdr_has_data = 1'b0, hdr_is_msg = 1'b0, hdr_msg_len_ok = 1'b0;
  logic [9:0] hdr_len = '0;
  logic hdr_digest = 1'b0;
  logic [1:0] hdr_func = '0;
  logic [3*NF-1:0] mps_cfg = CFG;
  logic ari_mode = 1'b0;
  logic bad_pulse, bad_pulse_m;
  logic [1:0] bad_reason, bad_reason_m;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  tlpchk_len_check #(.NUM_FUNC(NF), .POLICY(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .dw_vld(dw_vld), .dw_sop(dw_sop), .dw_eop(dw_eop),
    .hdr_has_data(hdr_has_data), .hdr_is_msg(hdr_is_msg), .hdr_msg_len_ok(hdr_msg_len_ok),
    .hdr_len(hdr_len), .hdr_digest(hdr_digest), .hdr_func(hdr_func),
    .mps_cfg(mps_cfg), .ari_mode(ari_mode), .bad_pulse(bad_pulse), .bad_reason(bad_reason)
  );

  tlpchk_len_check #(.NUM_FUNC(NF), .POLICY(1)) u_dut_max (
    .clk(clk), .rst_n(rst_n), .dw_vld(dw_vld), .dw_sop(dw_sop), .dw_eop(dw_eop),
    .hdr_has_data(hdr_has_data), .hdr_is_msg(hdr_is_msg), .hdr_msg_len_ok(hdr_msg_len_ok),
    .hdr_len(hdr_len), .hdr_digest(hdr_digest), .hdr_func(hdr_func),
    .mps_cfg(mps_cfg), .ari_mode(ari_mode), .bad_pulse(bad_pulse_m), .bad_reason(bad_reason_m)
  );

  task automatic check(input string tag, input logic p, input logic [1:0] r,
                       input logic [1:0] exp);
    checks++;
    if (p !== (exp != 2'd0) || r !== exp) begin
      failures++;
      $display("FAIL %s: pulse=%0b reason=%0d expected pulse=%0b reason=%0d",
               tag, p, r, exp != 2'd0, exp);
    end
  endtask

  task automatic send(input vec_t v);
    hdr_has_data   = v.has;
    hdr_is_msg     = v.msg;
    hdr_msg_len_ok = v.mlen;
    hdr_len        = v.len;
    hdr_digest     = v.dig;
    hdr_func       = v.func;
    ari_mode       = v.ari;
    for (int b = 0; b < int'(v.beats); b++) begin
      @(negedge clk);
      dw_vld = 1'b1;
      dw_sop = (b == 0);
      dw_eop = (b == int'(v.beats) - 1);
    end
    @(negedge clk);
    dw_vld = 1'b0;
    dw_sop = 1'b0;
    dw_eop = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R11: outputs quiet in and after reset
    repeat (3) @(negedge clk);
    check("R11 reset", bad_pulse, bad_reason, 2'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 after reset", bad_pulse, bad_reason, 2'd0);

    for (int i = 0; i < NV; i++) begin
      send(VECS[i]);
      check($sformatf("R%0d vec %0d", VECS[i].req, i), bad_pulse, bad_reason, VECS[i].exp);
    end

    // R11: a flagged isolated packet pulses for exactly one cycle
    send('{1'b1,1'b0,1'b0,10'd65,1'b0,2'd0,1'b0,12'd65,2'd1,4'd11});
    check("R11 pulse", bad_pulse, bad_reason, 2'd1);
    @(negedge clk);
    check("R11 pulse drops", bad_pulse, bad_reason, 2'd0);

    // R10: targeted policy versus largest-code policy, f1 (32 DW) vs max 1024 DW
    send('{1'b1,1'b0,1'b0,10'd100,1'b0,2'd1,1'b0,12'd100,2'd1,4'd10});
    check("R10 targeted", bad_pulse, bad_reason, 2'd1);
    check("R10 largest", bad_pulse_m, bad_reason_m, 2'd0);

    // R9: function-0 mode also overrides the largest-code policy (64 DW)
    send('{1'b1,1'b0,1'b0,10'd100,1'b0,2'd1,1'b1,12'd100,2'd1,4'd9});
    check("R9 largest overridden", bad_pulse_m, bad_reason_m, 2'd1);

    // R1: Length 0 carrying 1023 DWs mismatches under the 1024 DW limit
    send('{1'b1,1'b0,1'b0,10'd0,1'b0,2'd2,1'b0,12'd1023,2'd2,4'd1});
    check("R1 zero short", bad_pulse, bad_reason, 2'd2);

    // R4: code 5 gives 1024 DW; 1023 accepted on f2
    send('{1'b1,1'b0,1'b0,10'd1023,1'b0,2'd2,1'b0,12'd1023,2'd0,4'd4});
    check("R4 code 5", bad_pulse, bad_reason, 2'd0);

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule